// File: doc/BRIEF.md
# Per-Pixel Direct/Indexed Colour Selector

This block is one stage of a display pixel pipeline behind a framebuffer that keeps two colour planes and one control plane. For each pixel it receives three words: an 8-bit palette index from the indexed plane, a 32-bit word from the true-colour plane and a 32-bit control word. It produces one 24-bit RGB value per pixel. A code in the top byte of the control word decides, pixel by pixel, whether the true-colour word is used directly or the index is resolved through a palette.

The palette sits outside the block. The stage drives the index to a read port and takes the colour that comes back a fixed number of advancing cycles later. The direct-colour decision and the direct colour travel through a delay line of the same depth, so every output pixel meets its own palette result. Pixels enter and leave on valid/ready streams. A single advance signal moves the whole pipeline, palette included, so backpressure stalls every stage at once and no data is lost.

The stage also counts the position of each pixel inside a frame whose visible width and height are configuration inputs. Each output pixel carries a start-of-line flag, an end-of-frame flag and a plane word offset computed with a fixed line stride of 1024 pixels. A configuration input switches the stage into an 8-bit-only mode in which every pixel uses the palette.

Top module: `pix_colour_sel`

## Requirements
- R1: When `cfg_index_only` is 0 and bits 31:24 of `in_ctrl` equal 8'h03, the output colour is bits 23:0 of `in_direct`, with red in 23:16, green in 15:8 and blue in 7:0, laid out the same way on `out_rgb`.
- R2: For any other value of bits 31:24 of `in_ctrl`, the output colour is the palette colour returned for that pixel's `in_index`.
- R3: Bits 31:24 of `in_direct` and bits 23:0 of `in_ctrl` have no effect on the output.
- R4: When `cfg_index_only` is 1, every pixel takes its palette colour, whatever its control word holds.
- R5: `pal_rd_idx` equals `in_index` and `pal_adv` equals `in_ready`; the palette must present on `pal_rd_rgb` the colour for the index it saw PAL_LAT cycles earlier in which `pal_adv` was high.
- R6: Every accepted pixel leaves exactly once, in the order it was accepted, whatever pattern `out_ready` follows.
- R7: While `out_valid` is 1 and `out_ready` is 0, every output holds its value into the next cycle.
- R8: `out_sol` is 1 exactly for the first pixel of each line; `out_eof` is 1 exactly for the last pixel of the last line. Column and line wrap to 0 after width and height pixels.
- R9: `out_addr` equals line times 1024 plus column, the stride being fixed and independent of `cfg_width`.
- R10: Widths from 1 to 1024 and heights from 1 to 768 are handled, including the largest line number 767 and a width of one pixel.
- R11: After reset `out_valid` is 0 and the first accepted pixel is at column 0, line 0.
- R12: `in_ready` is 1 exactly when `out_valid` is 0 or `out_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | 11 | Visible pixels per line, 1 to 1024 |
| cfg_height | input | 10 | Visible lines per frame, 1 to 768 |
| cfg_index_only | input | 1 | 1 forces palette colour for every pixel |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Stage accepts the input pixel this cycle |
| in_index | input | 8 | Index from the indexed plane |
| in_direct | input | 32 | Word from the true-colour plane |
| in_ctrl | input | 32 | Word from the control plane |
| pal_rd_idx | output | 8 | Index sent to the palette |
| pal_adv | output | 1 | Palette pipeline advance enable |
| pal_rd_rgb | input | 24 | Colour returned by the palette |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Consumer takes the output pixel |
| out_rgb | output | 24 | Selected colour, red 23:16, green 15:8, blue 7:0 |
| out_sol | output | 1 | First pixel of a line |
| out_eof | output | 1 | Last pixel of a frame |
| out_addr | output | 20 | Plane word offset: line times 1024 plus column |

## Verification
The control byte is swept over all 256 values in alternation with the direct code, and the ignored bits of both words are varied, so a decoder that looks at the wrong bits or at too few of them gives a wrong colour. The same stream runs once in normal mode and once in 8-bit-only mode, which separates the mode override from the code decode. Frames of 5 by 3, 1024 by 2, 1 by 1 and 3 by 768 pixels exercise line and frame wrap, the full stride and the last line. Input gaps and an irregular `out_ready` pattern run at the same time to show that palette results stay aligned with their pixels through stalls.

// File: rtl/pxs_pkg.sv
package pxs_pkg;

    localparam logic [7:0] DIRECT_CODE = 8'h03;

    typedef struct packed {
        logic [7:0] red;
        logic [7:0] green;
        logic [7:0] blue;
    } rgb_t;

endpackage

// File: rtl/pxs_classify.sv
module pxs_classify
    import pxs_pkg::*;
(
    input  logic [31:0] ctrl_word,
    input  logic [31:0] direct_word,
    input  logic        index_only,
    output logic        use_direct,
    output rgb_t        direct_rgb
);

    logic [7:0] code;

    always_comb begin
        code       = ctrl_word[31:24];
        use_direct = !index_only && (code == DIRECT_CODE);
        direct_rgb.red   = direct_word[23:16];
        direct_rgb.green = direct_word[15:8];
        direct_rgb.blue  = direct_word[7:0];
    end

endmodule

// File: rtl/pxs_pos_track.sv
module pxs_pos_track #(
    parameter int STRIDE = 1024,
    parameter int MAX_W  = 1024,
    parameter int MAX_H  = 768,
    localparam int WX_W   = $clog2(MAX_W + 1),
    localparam int HY_W   = $clog2(MAX_H + 1),
    localparam int X_W    = $clog2(MAX_W),
    localparam int Y_W    = $clog2(MAX_H),
    localparam int ADDR_W = $clog2(STRIDE * MAX_H)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [WX_W-1:0]   cfg_width,
    input  logic [HY_W-1:0]   cfg_height,
    output logic              cur_sol,
    output logic              cur_eof,
    output logic [ADDR_W-1:0] cur_addr
);

    typedef struct packed {
        logic [X_W-1:0]    col;
        logic [Y_W-1:0]    row;
        logic [ADDR_W-1:0] base;
    } pos_t;

    pos_t pos_d, pos_q;
    logic last_col, last_row;

    always_comb begin
        last_col = (WX_W'(pos_q.col) == cfg_width - WX_W'(1));
        last_row = (HY_W'(pos_q.row) == cfg_height - HY_W'(1));
        cur_sol  = (pos_q.col == '0);
        cur_eof  = last_col && last_row;
        cur_addr = pos_q.base + ADDR_W'(pos_q.col);

        pos_d = pos_q;
        if (step) begin
            if (last_col) begin
                pos_d.col = '0;
                if (last_row) begin
                    pos_d.row  = '0;
                    pos_d.base = '0;
                end else begin
                    pos_d.row  = pos_q.row + Y_W'(1);
                    pos_d.base = pos_q.base + ADDR_W'(STRIDE);
                end
            end else begin
                pos_d.col = pos_q.col + X_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

endmodule

// File: rtl/pxs_delay.sv
module pxs_delay #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    generate
        if (DEPTH == 0) begin : g_pass
            assign dout = din;
        end else begin : g_line
            logic [WIDTH-1:0] stage_d [DEPTH];
            logic [WIDTH-1:0] stage_q [DEPTH];

            always_comb begin
                for (int k = 0; k < DEPTH; k++) begin
                    stage_d[k] = stage_q[k];
                end
                if (adv) begin
                    stage_d[0] = din;
                    for (int k = 1; k < DEPTH; k++) begin
                        stage_d[k] = stage_q[k-1];
                    end
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int k = 0; k < DEPTH; k++) stage_q[k] <= '0;
                end else begin
                    for (int k = 0; k < DEPTH; k++) stage_q[k] <= stage_d[k];
                end
            end

            assign dout = stage_q[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/pix_colour_sel.sv
module pix_colour_sel
    import pxs_pkg::*;
#(
    parameter int PAL_LAT = 2,
    parameter int STRIDE  = 1024,
    parameter int MAX_W   = 1024,
    parameter int MAX_H   = 768,
    localparam int WX_W   = $clog2(MAX_W + 1),
    localparam int HY_W   = $clog2(MAX_H + 1),
    localparam int ADDR_W = $clog2(STRIDE * MAX_H)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WX_W-1:0]   cfg_width,
    input  logic [HY_W-1:0]   cfg_height,
    input  logic              cfg_index_only,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_index,
    input  logic [31:0]       in_direct,
    input  logic [31:0]       in_ctrl,
    output logic [7:0]        pal_rd_idx,
    output logic              pal_adv,
    input  logic [23:0]       pal_rd_rgb,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [23:0]       out_rgb,
    output logic              out_sol,
    output logic              out_eof,
    output logic [ADDR_W-1:0] out_addr
);

    typedef struct packed {
        logic              valid;
        logic              use_direct;
        rgb_t              direct_rgb;
        logic              sol;
        logic              eof;
        logic [ADDR_W-1:0] addr;
    } side_t;

    typedef struct packed {
        logic              valid;
        rgb_t              rgb;
        logic              sol;
        logic              eof;
        logic [ADDR_W-1:0] addr;
    } outreg_t;

    localparam int SIDE_W = $bits(side_t);

    logic              adv;
    logic              accept;
    logic              use_direct;
    rgb_t              direct_rgb;
    logic              cur_sol, cur_eof;
    logic [ADDR_W-1:0] cur_addr;
    side_t             side_in, side_out;
    logic [SIDE_W-1:0] side_out_vec;
    outreg_t           out_d, out_q;

    assign adv    = !out_q.valid || out_ready;
    assign accept = in_valid && adv;

    pxs_classify u_classify (
        .ctrl_word   (in_ctrl),
        .direct_word (in_direct),
        .index_only  (cfg_index_only),
        .use_direct  (use_direct),
        .direct_rgb  (direct_rgb)
    );

    pxs_pos_track #(
        .STRIDE (STRIDE),
        .MAX_W  (MAX_W),
        .MAX_H  (MAX_H)
    ) u_pos (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (accept),
        .cfg_width  (cfg_width),
        .cfg_height (cfg_height),
        .cur_sol    (cur_sol),
        .cur_eof    (cur_eof),
        .cur_addr   (cur_addr)
    );

    always_comb begin
        side_in.valid      = in_valid;
        side_in.use_direct = use_direct;
        side_in.direct_rgb = direct_rgb;
        side_in.sol        = cur_sol;
        side_in.eof        = cur_eof;
        side_in.addr       = cur_addr;
    end

    pxs_delay #(
        .WIDTH (SIDE_W),
        .DEPTH (PAL_LAT)
    ) u_align (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .din   (side_in),
        .dout  (side_out_vec)
    );

    assign side_out = side_t'(side_out_vec);

    always_comb begin
        out_d = out_q;
        if (adv) begin
            out_d.valid = side_out.valid;
            out_d.rgb   = side_out.use_direct ? side_out.direct_rgb : rgb_t'(pal_rd_rgb);
            out_d.sol   = side_out.sol;
            out_d.eof   = side_out.eof;
            out_d.addr  = side_out.addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign in_ready   = adv;
    assign pal_adv    = adv;
    assign pal_rd_idx = in_index;
    assign out_valid  = out_q.valid;
    assign out_rgb    = out_q.rgb;
    assign out_sol    = out_q.sol;
    assign out_eof    = out_q.eof;
    assign out_addr   = out_q.addr;

endmodule

// File: rtl/pix_colour_sel_chk.sv
module pix_colour_sel_chk #(
    parameter int STRIDE = 1024,
    parameter int WX_W   = 11,
    parameter int HY_W   = 10,
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WX_W-1:0]   cfg_width,
    input logic [HY_W-1:0]   cfg_height,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [23:0]       out_rgb,
    input logic              out_sol,
    input logic              out_eof,
    input logic [ADDR_W-1:0] out_addr
);

    localparam logic [ADDR_W-1:0] STRIDE_A = ADDR_W'(STRIDE);

    logic [ADDR_W-1:0] col, row;
    assign col = out_addr % STRIDE_A;
    assign row = out_addr / STRIDE_A;

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_rgb) && $stable(out_addr)
                                    && $stable(out_sol) && $stable(out_eof));

    // R12
    stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    // R8
    sol_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_sol |-> col == '0);

    // R8
    eof_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_eof |-> col == ADDR_W'(cfg_width) - ADDR_W'(1)
                                 && row == ADDR_W'(cfg_height) - ADDR_W'(1));

    // R9
    col_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> col < ADDR_W'(cfg_width));

    // R11
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

endmodule

bind pix_colour_sel pix_colour_sel_chk #(
    .STRIDE (STRIDE),
    .WX_W   (WX_W),
    .HY_W   (HY_W),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_width  (cfg_width),
    .cfg_height (cfg_height),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_rgb    (out_rgb),
    .out_sol    (out_sol),
    .out_eof    (out_eof),
    .out_addr   (out_addr)
);

// File: tb/pix_colour_sel_tb_top.sv
module pix_colour_sel_tb_top;

    localparam int PAL_LAT = 2;
    localparam int TOTAL   = 600 + 300 + 2048 + 10 + 2304;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] cfg_width = 11'd5;
    logic [9:0]  cfg_height = 10'd3;
    logic        cfg_index_only = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_index = '0;
    logic [31:0] in_direct = '0;
    logic [31:0] in_ctrl = '0;
    logic [7:0]  pal_rd_idx;
    logic        pal_adv;
    logic [23:0] pal_rd_rgb;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [23:0] out_rgb;
    logic        out_sol, out_eof;
    logic [19:0] out_addr;

    always #10 clk = ~clk;

    pix_colour_sel #(.PAL_LAT(PAL_LAT)) dut_i (.*);

    function automatic logic [23:0] pal_fn(input logic [7:0] ix);
        return {ix ^ 8'hA5, ~ix, ix + 8'd29};
    endfunction

    logic [23:0] pal_pipe [PAL_LAT];
    always_ff @(posedge clk) begin
        if (pal_adv) begin
            pal_pipe[0] <= pal_fn(pal_rd_idx);
            for (int k = 1; k < PAL_LAT; k++) pal_pipe[k] <= pal_pipe[k-1];
        end
    end
    assign pal_rd_rgb = pal_pipe[PAL_LAT-1];

    int checks = 0, fails = 0, cyc = 0;
    int wr_cnt = 0, rd_cnt = 0;
    int px = 0, py = 0;
    bit done = 0;

    logic [23:0] e_rgb [TOTAL];
    logic        e_sol [TOTAL];
    logic        e_eof [TOTAL];
    logic [19:0] e_addr[TOTAL];
    string       e_tag [TOTAL];
    string       e_ptag[TOTAL];

    logic        prev_stall = 0;
    logic [23:0] prev_rgb;
    logic [19:0] prev_addr;
    logic        prev_sol, prev_eof;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    function automatic logic [31:0] ctrl_of(input int i);
        logic [7:0] top;
        top = i[0] ? 8'h03 : 8'(i >> 1);
        return {top, 24'(i * 40503)};
    endfunction

    function automatic logic [31:0] dir_of(input int i);
        return {8'(i * 91), 24'(i * 2654435) ^ 24'h5A5A5A};
    endfunction

    // one cycle: drive at negedge, sample after settling
    task automatic step(input bit offer, input int w, input int h);
        @(negedge clk);
        cyc++;
        out_ready = !((cyc % 7) == 3 || (cyc % 11) < 2);
        in_valid  = offer && ((cyc % 5) != 4);
        in_index  = 8'(wr_cnt * 37 + 11);
        in_ctrl   = ctrl_of(wr_cnt);
        in_direct = dir_of(wr_cnt);
        #1;
        chk(in_ready == (out_ready || !out_valid), "R12", "in_ready",
            in_ready, out_ready || !out_valid);
        if (in_valid) begin
            chk(pal_rd_idx == in_index && pal_adv == in_ready, "R5", "palette port",
                {pal_adv, pal_rd_idx}, {in_ready, in_index});
        end
        if (prev_stall) begin
            chk(out_valid && out_rgb == prev_rgb && out_addr == prev_addr &&
                out_sol == prev_sol && out_eof == prev_eof, "R7", "held output",
                {out_valid, out_rgb}, {1'b1, prev_rgb});
        end
        prev_stall = out_valid && !out_ready;
        prev_rgb = out_rgb; prev_addr = out_addr; prev_sol = out_sol; prev_eof = out_eof;
        if (out_valid && out_ready) begin
            if (rd_cnt >= wr_cnt) begin
                chk(0, "R6", "extra output", rd_cnt, wr_cnt);
            end else begin
                chk(out_rgb == e_rgb[rd_cnt], e_tag[rd_cnt], "rgb", out_rgb, e_rgb[rd_cnt]);
                chk(out_sol == e_sol[rd_cnt] && out_eof == e_eof[rd_cnt], "R8",
                    "sol/eof", {out_sol, out_eof}, {e_sol[rd_cnt], e_eof[rd_cnt]});
                chk(out_addr == e_addr[rd_cnt], e_ptag[rd_cnt], "addr",
                    out_addr, e_addr[rd_cnt]);
                if (rd_cnt == 0) begin
                    chk(out_addr == 0 && out_sol, "R11", "first pixel position",
                        out_addr, 0);
                end
            end
            rd_cnt++;
        end
        if (in_valid && in_ready) begin
            logic [31:0] c, d;
            c = in_ctrl; d = in_direct;
            if (!cfg_index_only && c[31:24] == 8'h03) begin
                e_rgb[wr_cnt] = d[23:0];
                e_tag[wr_cnt] = (d[31:24] != 0) ? "R3" : "R1";
            end else begin
                e_rgb[wr_cnt] = pal_fn(in_index);
                e_tag[wr_cnt] = cfg_index_only ? "R4" : "R2";
            end
            e_sol[wr_cnt]  = (px == 0);
            e_eof[wr_cnt]  = (px == w - 1) && (py == h - 1);
            e_addr[wr_cnt] = 20'(py * 1024 + px);
            e_ptag[wr_cnt] = (w == 1 || w == 1024 || h == 768) ? "R10" : "R9";
            wr_cnt++;
            if (px == w - 1) begin
                px = 0;
                py = (py == h - 1) ? 0 : py + 1;
            end else begin
                px++;
            end
        end
    endtask

    task automatic drain(input int w, input int h);
        while (rd_cnt < wr_cnt) step(0, w, h);
        step(0, w, h);
    endtask

    task automatic run_seg(input int w, input int h, input bit mode, input int n);
        int stop;
        drain(int'(cfg_width), int'(cfg_height));
        @(negedge clk);
        cfg_width = 11'(w);
        cfg_height = 10'(h);
        cfg_index_only = mode;
        stop = wr_cnt + n;
        while (wr_cnt < stop) step(1, w, h);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R11
        chk(!out_valid, "R11", "out_valid in reset", out_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!out_valid && in_ready, "R11", "idle after reset", {out_valid, in_ready}, 2'b01);
        run_seg(5, 3, 1'b0, 600);
        run_seg(5, 3, 1'b1, 300);
        run_seg(1024, 2, 1'b0, 2048);
        run_seg(1, 1, 1'b0, 10);
        run_seg(3, 768, 1'b1, 2304);
        drain(3, 768);
        repeat (4) step(0, 3, 768);
        // R6
        chk(rd_cnt == TOTAL && wr_cnt == TOTAL, "R6", "pixel count", rd_cnt, TOTAL);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", rd_cnt, TOTAL);
            summary();
            $finish;
        end
    end

endmodule